// File: doc/BRIEF.md
# Two-Pass Countdown Watchdog Timer

This block is a watchdog built around a 10-bit down-counter that steps once per cycle in which the `tick` input is high. Software programs a reload value and then keeps the system alive by writing a kick command. The kick command reloads the counter before it runs out. When the counter is at zero and another tick arrives, the timer expires.

A parameter picks one of two behaviours. With `VERSION = 1` the first expiry does not reset anything. It sets a sticky timeout status bit, raises a one-cycle interrupt pulse and reloads the counter. A reset request follows only if the counter expires again while that status bit is still set. Clearing the bit with a write-one re-arms the two-pass rule. With `VERSION = 2` every expiry raises the reset request directly.

The reset request is a single-cycle pulse. Alongside it the block sets a latched flag that records a reset has occurred, and only the power-on reset clears that flag. A small register port gives access to four word registers: kick/count, reload value, status and control. The control register holds a halt bit that freezes the count.

Top module: `wdog_twopass`

## Requirements
- R1: After power-on reset the count and the reload value both equal `INIT_RESET` (64). The status and control registers read 0, and `wdt_irq`, `wdt_rst_req` and `rst_seen` are low.
- R2: A write to address 0 with data bit 0 set loads the count from the reload value. A write to address 0 with bit 0 clear has no effect on the count. A read of address 0 returns the current count in bits 9:0.
- R3: A write to address 1 stores data bits 9:0 as the reload value when that value is 4 or more. A value of 0, 1, 2 or 3 is dropped and the stored value is kept. A read of address 1 returns the reload value.
- R4: In each cycle with `tick` high and halt clear, a non-zero count drops by one. A tick that arrives while the count is zero is an expiry, and an expiry reloads the count from the reload value.
- R5: With `VERSION = 1`, an expiry while status bit 3 is clear does the following: it sets status bit 3, reloads the count, and drives `wdt_irq` high for exactly one cycle. It does not request a reset.
- R6: With `VERSION = 1`, an expiry while status bit 3 is set drives `wdt_rst_req` high for exactly one cycle.
- R7: A write to address 2 with data bit 3 set clears status bit 3. With bit 3 clear, the write leaves it unchanged. After a clear, the next expiry behaves as a first expiry again.
- R8: With `VERSION = 2`, each expiry drives `wdt_rst_req` high for one cycle and reloads the count. `wdt_irq` stays low and status bit 3 stays 0.
- R9: Control register bit 0 at address 3 is the halt bit. While it is set, ticks do not change the count. It reads 0 after reset.
- R10: Each reset request sets `rst_seen`, which also reads as status bit 0. It stays set through later writes and expiries until `por_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Count enable strobe, one step per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 kick/count, 1 reload value, 2 status, 3 control |
| bus_wdata | input | 10 | Register write data |
| bus_rdata | output | 10 | Register read data, combinational from `bus_addr` |
| wdt_irq | output | 1 | One-cycle pulse on a first expiry (version 1 only) |
| wdt_rst_req | output | 1 | One-cycle reset request pulse |
| rst_seen | output | 1 | Latched flag showing that a reset request has occurred |

## Verification
The checker relies on three properties of the input traffic:
- Reload writes never coincide with an expiry. Because of this, the count seen during an interrupt pulse equals the stored reload value.
- A status clear never lands in the same cycle as an expiry.
- The write strobe and address are always known values.

The directed tests respect these limits by issuing each register write in a cycle with `tick` low and by spacing ticks one cycle apart. Because the stored reload value is never below 4, two reset pulses can never fall in adjacent cycles. The checker depends on that spacing for its single-cycle pulse property.

// File: rtl/wdog_twopass.sv
module wdog_twopass #(
  parameter int VERSION    = 1,
  parameter int CNT_W      = 10,
  parameter int INIT_RESET = 64,
  parameter int MIN_INIT   = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             wdt_irq,
  output logic             wdt_rst_req,
  output logic             rst_seen
);

  localparam logic [1:0] A_KICK = 2'd0;
  localparam logic [1:0] A_INIT = 2'd1;
  localparam logic [1:0] A_STS  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;
  localparam int TO_BIT   = 3;
  localparam int SEEN_BIT = 0;
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_RESET);
  localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_INIT);
  localparam bit TWO_PASS = (VERSION == 1);

  logic [CNT_W-1:0] cnt_q, init_q;
  logic             to_q, halt_q, irq_q, rst_q, seen_q;

  wire wr_kick = bus_wr && (bus_addr == A_KICK) && bus_wdata[0];
  wire wr_init = bus_wr && (bus_addr == A_INIT) && (bus_wdata >= MIN_V);
  wire wr_clr  = bus_wr && (bus_addr == A_STS) && bus_wdata[TO_BIT];
  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);

  wire step   = tick && !halt_q;
  wire expire = step && (cnt_q == '0);
  wire first  = expire && TWO_PASS && !to_q;
  wire fire   = expire && (!TWO_PASS || to_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= INIT_V;
    end else if (wr_kick || expire) begin
      cnt_q <= init_q;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) init_q <= INIT_V;
    else if (wr_init) init_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) halt_q <= 1'b0;
    else if (wr_ctrl) halt_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) to_q <= 1'b0;
    else if (first) to_q <= 1'b1;
    else if (wr_clr) to_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      irq_q <= first;
      rst_q <= fire;
      if (fire) seen_q <= 1'b1;
    end
  end

  logic [CNT_W-1:0] sts_word, ctrl_word;
  always_comb begin
    sts_word = '0;
    sts_word[TO_BIT] = to_q;
    sts_word[SEEN_BIT] = seen_q;
    ctrl_word = '0;
    ctrl_word[0] = halt_q;
  end

  always_comb begin
    unique case (bus_addr)
      A_KICK:  bus_rdata = cnt_q;
      A_INIT:  bus_rdata = init_q;
      A_STS:   bus_rdata = sts_word;
      default: bus_rdata = ctrl_word;
    endcase
  end

  assign wdt_irq     = irq_q;
  assign wdt_rst_req = rst_q;
  assign rst_seen    = seen_q;

endmodule

// File: rtl/wdog_twopass_chk.sv
module wdog_twopass_chk #(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4
) (
  input logic             clk,
  input logic             por_n,
  input logic             tick,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init,
  input logic             halt,
  input logic             irq,
  input logic             rst_req,
  input logic             seen
);

  wire kick_wr = bus_wr && (bus_addr == 2'd0) && bus_wdata[0];

  a_r3_init_floor: assert property (@(posedge clk) disable iff (!por_n)
    init >= CNT_W'(MIN_INIT));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!por_n)
    (tick && !halt && !kick_wr && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (!por_n)
    (halt && !kick_wr) |=> $stable(count));

  a_r5_irq_reloads: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (count == init));

  a_r6_rst_single: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!por_n)
    irq |=> !irq);

  a_r8_irq_rst_excl: assert property (@(posedge clk) disable iff (!por_n)
    !(irq && rst_req));

  a_r10_seen_with_rst: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> seen);

  a_r10_seen_sticky: assert property (@(posedge clk) disable iff (!por_n)
    seen |=> seen);

endmodule

bind wdog_twopass wdog_twopass_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
  .clk(clk), .por_n(por_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .count(cnt_q), .init(init_q), .halt(halt_q),
  .irq(irq_q), .rst_req(rst_q), .seen(seen_q)
);

// File: tb/wdog_twopass_test.sv
module wdog_twopass_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic tick = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [9:0] bus_wdata = '0;
  logic [9:0] rd1, rd2;
  logic irq1, rst1, seen1, irq2, rst2, seen2;
  int checks = 0;
  int failures = 0;
  int irq1_n = 0, rst1_n = 0, irq2_n = 0, rst2_n = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_twopass #(.VERSION(1)) uut (
    .clk(clk), .por_n(por_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .wdt_irq(irq1), .wdt_rst_req(rst1),
    .rst_seen(seen1));

  wdog_twopass #(.VERSION(2)) uut_v2 (
    .clk(clk), .por_n(por_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd2), .wdt_irq(irq2), .wdt_rst_req(rst2),
    .rst_seen(seen2));

  always @(negedge clk) begin
    if (irq1) irq1_n++;
    if (rst1) rst1_n++;
    if (irq2) irq2_n++;
    if (rst2) rst2_n++;
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v1, output int v2);
    @(negedge clk);
    bus_addr = a;
    #1;
    v1 = rd1; v2 = rd2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    int a, b;
    rd(2'd0, a, b); chk(a, 64, "R1 count v1"); chk(b, 64, "R1 count v2");
    rd(2'd1, a, b); chk(a, 64, "R1 reload v1");
    rd(2'd2, a, b); chk(a, 0, "R1 status v1"); chk(b, 0, "R1 status v2");
    rd(2'd3, a, b); chk(a, 0, "R1 R9 halt clear at reset");
    chk(irq1 | rst1 | seen1 | irq2 | rst2 | seen2, 0, "R1 outputs low");
  endtask

  task automatic t_init;
    int a, b;
    wr(2'd1, 10'd2); rd(2'd1, a, b); chk(a, 64, "R3 value 2 ignored");
    wr(2'd1, 10'd3); rd(2'd1, a, b); chk(b, 64, "R3 value 3 ignored");
    wr(2'd1, 10'd0); rd(2'd1, a, b); chk(a, 64, "R3 value 0 ignored");
    wr(2'd1, 10'd4); rd(2'd1, a, b); chk(a, 4, "R3 value 4 stored");
    wr(2'd1, 10'd8); rd(2'd1, a, b); chk(b, 8, "R3 value 8 stored");
  endtask

  task automatic t_kick;
    int a, b;
    wr(2'd0, 10'd0); rd(2'd0, a, b); chk(a, 64, "R2 kick bit0 clear no effect");
    ticks(3); rd(2'd0, a, b); chk(a, 61, "R4 three ticks"); chk(b, 61, "R4 three ticks v2");
    wr(2'd0, 10'd1); rd(2'd0, a, b); chk(a, 8, "R2 kick reloads");
    ticks(2); wr(2'd0, 10'd2); rd(2'd0, a, b); chk(a, 6, "R2 kick with bit0 clear ignored");
  endtask

  task automatic t_halt;
    int a, b;
    wr(2'd3, 10'd1); rd(2'd3, a, b); chk(a, 1, "R9 halt reads back");
    ticks(3); rd(2'd0, a, b); chk(a, 6, "R9 halted count frozen");
    wr(2'd3, 10'd0); ticks(1); rd(2'd0, a, b); chk(a, 5, "R9 count resumes");
  endtask

  task automatic t_two_pass;
    int a, b, i1, r1, i2, r2;
    wr(2'd0, 10'd1);
    i1 = irq1_n; r1 = rst1_n; i2 = irq2_n; r2 = rst2_n;
    ticks(8); rd(2'd0, a, b); chk(a, 0, "R4 count reaches zero");
    chk(irq1_n - i1, 0, "R4 no expiry at zero");
    ticks(1);
    chk(irq1_n - i1, 1, "R5 one irq cycle on first expiry");
    chk(rst1_n - r1, 0, "R5 no reset on first expiry");
    rd(2'd2, a, b); chk(a, 8, "R5 status bit3 set");
    rd(2'd0, a, b); chk(a, 8, "R5 count reloaded");
    chk(rst2_n - r2, 1, "R8 v2 reset on single expiry");
    chk(irq2_n - i2, 0, "R8 v2 no irq");
    chk(b, 8, "R8 v2 count reloaded");
    rd(2'd2, a, b); chk(b, 1, "R8 R10 v2 status bit3 clear, seen set");
    ticks(9);
    chk(rst1_n - r1, 1, "R6 one reset cycle on second expiry");
    chk(irq1_n - i1, 1, "R6 no extra irq");
    chk(seen1, 1, "R10 rst_seen set");
    rd(2'd2, a, b); chk(a, 9, "R10 status bits 3 and 0");
  endtask

  task automatic t_rearm;
    int a, b, i1, r1;
    wr(2'd2, 10'd1); rd(2'd2, a, b); chk(a, 9, "R7 R10 write without bit3 keeps status");
    wr(2'd2, 10'd8); rd(2'd2, a, b); chk(a, 1, "R7 write one clears bit3");
    wr(2'd0, 10'd1);
    i1 = irq1_n; r1 = rst1_n;
    ticks(9);
    chk(irq1_n - i1, 1, "R7 re-armed expiry gives irq");
    chk(rst1_n - r1, 0, "R7 re-armed expiry no reset");
    chk(seen1, 1, "R10 seen held");
  endtask

  task automatic t_por;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk(seen1, 0, "R10 por clears seen v1");
    chk(seen2, 0, "R10 por clears seen v2");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset;
    t_init;
    t_kick;
    t_halt;
    t_two_pass;
    t_rearm;
    t_por;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule